// File: doc/BRIEF.md
# Bus Master Retry and Ready-Wait Guard

This block watches one bus master's transactions for two failure modes: targets that keep answering with a retry, and targets that hold off the ready handshake too long during a data phase. A transaction opens with a start pulse and closes with a done pulse. While it is open, each retry termination is counted. If the count stays within a programmable limit, the block asks the master to reissue the request after one idle cycle. If the count goes past the limit, the block cancels the transaction and records the cancellation in a sticky status bit.

In parallel, a beat timer counts consecutive data-phase beats in which the target is not ready. When the count reaches a second programmable limit, the block ends the transaction with an error pulse and sets a second sticky bit. For both limits, a value of zero has a special meaning: zero retries means no limit, and a zero beat limit turns the timer off. Software clears each sticky bit by writing a one to its position. Writing a zero leaves the bit as it is.

Top module: `mst_retry_guard`

## Requirements
- R1: After reset, `reissue`, `abort`, `timeout_err`, `sts_retry_aborted` and `sts_trdy_timeout` are all 0.
- R2: A retry that leaves the running count at or below a nonzero limit, or any retry when the limit is 0, raises `reissue` for one cycle. The pulse appears two cycles after the cycle in which the retry is sampled, so one idle cycle lies between them. `abort` stays low.
- R3: With a nonzero retry limit L, retry number L+1 of one transaction raises `abort` for one cycle, in the cycle after the retry is sampled. No `reissue` follows it, and the transaction closes.
- R4: With a retry limit of 0, any number of retries never raises `abort`. The bench uses 300 retries.
- R5: `sts_retry_aborted` is set on the cycle `abort` rises. It holds until a clear write (`clr_wr`=1) carries a 1 in `clr_data` bit 0. A clear write with bit 0 equal to 0 leaves it set.
- R6: A `txn_start` pulse resets the retry count to zero.
- R7: With a nonzero beat limit N, N consecutive open-transaction beats with `data_wait`=1 and `tgt_ready`=0 raise `timeout_err` for one cycle, in the cycle after the Nth such beat. The same event sets `sts_trdy_timeout`, which is cleared by a clear write with `clr_data` bit 1 equal to 1.
- R8: With a beat limit of 0, `timeout_err` never rises, however long the wait lasts.
- R9: A beat with `tgt_ready`=1 restarts the wait count from zero.
- R10: A timeout closes the transaction. Further waiting beats raise no second `timeout_err` until a new `txn_start`.
- R11: When a set event and a clear write hit the same sticky bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Opens a new transaction and clears the counts |
| txn_done | input | 1 | Transaction finished normally |
| tgt_retry | input | 1 | Target ended the current attempt with a retry |
| data_wait | input | 1 | Master is in a data phase awaiting the target |
| tgt_ready | input | 1 | Target ready on this beat |
| cfg_retry_limit | input | 8 | Retry limit; 0 means unlimited |
| cfg_trdy_limit | input | 8 | Ready-wait beat limit; 0 disables the timer |
| clr_wr | input | 1 | Status write strobe (write-1-to-clear) |
| clr_data | input | 2 | Clear mask: bit 0 retry-aborted, bit 1 timeout |
| reissue | output | 1 | One-cycle request to reissue the transaction |
| abort | output | 1 | One-cycle cancellation after too many retries |
| timeout_err | output | 1 | One-cycle error end after a ready-wait timeout |
| sts_retry_aborted | output | 1 | Sticky retry-abort status |
| sts_trdy_timeout | output | 1 | Sticky timeout status |

## Verification
Each count in this block shows up at the ports within a cycle or two of the event that completes it. A retry count that is off by one moves the `abort` pulse to a different retry number than L+1. A beat count that is not restarted by a ready beat, or by a new start, produces `timeout_err` earlier or later than the computed beat. A stuck transaction-open flag shows up either as a second timeout or as retries that are silently ignored. The sweeps step every small limit value and compare the exact retry number and beat number at which each pulse appears. Sticky state is read back right after each set, clear and simultaneous set-and-clear write.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int unsigned STS_RETRY = 0;
  localparam int unsigned STS_TMO   = 1;
  localparam int unsigned STS_N     = 2;
endpackage

// File: rtl/mrg_retry_ctr.sv
module mrg_retry_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         active,
  input  logic         retry,
  input  logic [W-1:0] limit,
  output logic         reissue_ev,
  output logic         abort_ev
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt;
  logic [W:0]   cnt_nxt;
  logic         retry_ev;
  logic         over;

  function automatic logic over_limit(input logic [W:0] n, input logic [W-1:0] lim);
    return (lim != '0) && (n > {1'b0, lim});
  endfunction

  assign retry_ev   = active && retry;
  assign cnt_nxt    = {1'b0, cnt} + 1'b1;
  assign over       = over_limit(cnt_nxt, limit);
  assign abort_ev   = retry_ev && over;
  assign reissue_ev = retry_ev && !over;

  always_ff @(posedge clk) begin
    if (!rst_n || start) cnt <= '0;
    else if (retry_ev && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R4
  unlimited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !abort_ev);
  // R3
  abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_ev && reissue_ev));
endmodule

// File: rtl/mrg_beat_timer.sv
module mrg_beat_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         active,
  input  logic         waiting,
  input  logic         ready,
  input  logic         suppress,
  input  logic [W-1:0] limit,
  output logic         tmo_ev
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] beats;
  logic [W:0]   beats_nxt;
  logic         stall;
  logic         hit;

  function automatic logic reached(input logic [W:0] n, input logic [W-1:0] lim);
    return (lim != '0) && (n == {1'b0, lim});
  endfunction

  assign stall     = active && waiting && !ready;
  assign beats_nxt = {1'b0, beats} + 1'b1;
  assign hit       = stall && reached(beats_nxt, limit);
  assign tmo_ev    = hit && !suppress;

  always_ff @(posedge clk) begin
    if (!rst_n || start || !active || ready || hit) beats <= '0;
    else if (stall && beats != CNT_MAX) beats <= beats + 1'b1;
  end

  // R8
  tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !tmo_ev);
  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ready && !start) |=> !tmo_ev || (limit == 8'd1));
endmodule

// File: rtl/mrg_sticky.sv
module mrg_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                       q[i] <= 1'b0;
      else if (set[i])                  q[i] <= 1'b1;
      else if (clr_en && clr_mask[i])   q[i] <= 1'b0;
    end

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !(clr_en && clr_mask[i])) |=> q[i]);
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/mst_retry_guard.sv
module mst_retry_guard
  import mrg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start,
  input  logic             txn_done,
  input  logic             tgt_retry,
  input  logic             data_wait,
  input  logic             tgt_ready,
  input  logic [CNT_W-1:0] cfg_retry_limit,
  input  logic [CNT_W-1:0] cfg_trdy_limit,
  input  logic             clr_wr,
  input  logic [1:0]       clr_data,
  output logic             reissue,
  output logic             abort,
  output logic             timeout_err,
  output logic             sts_retry_aborted,
  output logic             sts_trdy_timeout
);
  logic             active;
  logic             reissue_ev;
  logic             abort_ev;
  logic             tmo_ev;
  logic             reissue_pend;
  logic [STS_N-1:0] sts_set;
  logic [STS_N-1:0] sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                             active <= 1'b0;
    else if (txn_start)                     active <= 1'b1;
    else if (txn_done || abort_ev || tmo_ev) active <= 1'b0;
  end

  mrg_retry_ctr #(.W(CNT_W)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (txn_start),
    .active     (active),
    .retry      (tgt_retry),
    .limit      (cfg_retry_limit),
    .reissue_ev (reissue_ev),
    .abort_ev   (abort_ev)
  );

  mrg_beat_timer #(.W(CNT_W)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (txn_start),
    .active   (active),
    .waiting  (data_wait),
    .ready    (tgt_ready),
    .suppress (tgt_retry),
    .limit    (cfg_trdy_limit),
    .tmo_ev   (tmo_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reissue_pend <= 1'b0;
      reissue      <= 1'b0;
      abort        <= 1'b0;
      timeout_err  <= 1'b0;
    end else begin
      reissue_pend <= reissue_ev && !txn_start;
      reissue      <= reissue_pend && !txn_start;
      abort        <= abort_ev;
      timeout_err  <= tmo_ev;
    end
  end

  always_comb begin
    sts_set            = '0;
    sts_set[STS_RETRY] = abort_ev;
    sts_set[STS_TMO]   = tmo_ev;
  end

  mrg_sticky #(.N(STS_N)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (sts_set),
    .clr_en   (clr_wr),
    .clr_mask (clr_data),
    .q        (sts_q)
  );

  assign sts_retry_aborted = sts_q[STS_RETRY];
  assign sts_trdy_timeout  = sts_q[STS_TMO];

  // R2
  reissue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reissue_ev && !txn_start) |=> !reissue ##1 (reissue || $past(txn_start)));
  // R3
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> abort && sts_retry_aborted);
  // R7
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> timeout_err && sts_trdy_timeout);
  // R10
  tmo_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_ev && !txn_start) |=> !active);
  // R3
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort && reissue));
endmodule

// File: tb/mst_retry_guard_tb_top.sv
module mst_retry_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txn_start = 0, txn_done = 0, tgt_retry = 0, data_wait = 0, tgt_ready = 0;
  logic [7:0] cfg_retry_limit = 0, cfg_trdy_limit = 0;
  logic       clr_wr = 0;
  logic [1:0] clr_data = 0;
  logic       reissue, abort, timeout_err, sts_retry_aborted, sts_trdy_timeout;
  int         n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  mst_retry_guard dut_i (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_done(txn_done),
    .tgt_retry(tgt_retry), .data_wait(data_wait), .tgt_ready(tgt_ready),
    .cfg_retry_limit(cfg_retry_limit), .cfg_trdy_limit(cfg_trdy_limit),
    .clr_wr(clr_wr), .clr_data(clr_data), .reissue(reissue), .abort(abort),
    .timeout_err(timeout_err), .sts_retry_aborted(sts_retry_aborted),
    .sts_trdy_timeout(sts_trdy_timeout));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic begin_txn();
    @(negedge clk) txn_start = 1;
    @(negedge clk) txn_start = 0;
  endtask

  task automatic end_txn();
    @(negedge clk) txn_done = 1;
    @(negedge clk) txn_done = 0;
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk) begin clr_wr = 1; clr_data = m; end
    @(negedge clk) begin clr_wr = 0; clr_data = 0; end
  endtask

  // retry sampled at one edge; abort visible one cycle later, reissue two
  task automatic do_retry(input bit exp_abort, input string req);
    @(negedge clk) tgt_retry = 1;
    @(negedge clk) tgt_retry = 0;
    check(req, abort, exp_abort);
    check(req, reissue, 0);
    @(negedge clk);
    check(req, reissue, !exp_abort);
    check(req, abort, 0);
  endtask

  // drive one stalled beat and check the timeout pulse after the edge
  task automatic stall_beat(input bit rdy, input bit exp_tmo, input string req);
    @(negedge clk) begin data_wait = 1; tgt_ready = rdy; end
    @(negedge clk) begin data_wait = 0; tgt_ready = 0; end
    check(req, timeout_err, exp_tmo);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1", reissue, 0); check("R1", abort, 0); check("R1", timeout_err, 0);
    check("R1", sts_retry_aborted, 0); check("R1", sts_trdy_timeout, 0);

    // R2 R3 R5: sweep nonzero retry limits
    for (int lim = 1; lim <= 5; lim++) begin
      cfg_retry_limit = 8'(lim);
      begin_txn();
      for (int k = 1; k <= lim + 1; k++) do_retry(k == lim + 1, (k == lim + 1) ? "R3" : "R2");
      check("R5", sts_retry_aborted, 1);
      clear(2'b10);
      check("R5", sts_retry_aborted, 1);
      clear(2'b01);
      check("R5", sts_retry_aborted, 0);
    end

    // R4: unlimited
    cfg_retry_limit = 0;
    begin_txn();
    for (int k = 1; k <= 300; k++) do_retry(0, "R4");
    check("R4", sts_retry_aborted, 0);
    end_txn();

    // R6: start restarts retry count
    cfg_retry_limit = 3;
    begin_txn();
    do_retry(0, "R6"); do_retry(0, "R6");
    begin_txn();
    do_retry(0, "R6"); do_retry(0, "R6"); do_retry(0, "R6");
    do_retry(1, "R6");

    // R11: set and clear in the same cycle
    cfg_retry_limit = 1;
    clear(2'b01);
    check("R11", sts_retry_aborted, 0);
    begin_txn();
    do_retry(0, "R11");
    @(negedge clk) begin tgt_retry = 1; clr_wr = 1; clr_data = 2'b01; end
    @(negedge clk) begin tgt_retry = 0; clr_wr = 0; clr_data = 0; end
    check("R11", abort, 1);
    check("R11", sts_retry_aborted, 1);
    clear(2'b01);

    // R7 R10: sweep beat limits
    for (int n = 1; n <= 6; n++) begin
      cfg_trdy_limit = 8'(n);
      begin_txn();
      for (int b = 1; b <= 2 * n + 2; b++) stall_beat(0, b == n, (b > n) ? "R10" : "R7");
      check("R7", sts_trdy_timeout, 1);
      clear(2'b01);
      check("R7", sts_trdy_timeout, 1);
      clear(2'b10);
      check("R7", sts_trdy_timeout, 0);
    end

    // R9: ready beat restarts wait count
    for (int n = 2; n <= 5; n++) begin
      cfg_trdy_limit = 8'(n);
      begin_txn();
      for (int b = 1; b < n; b++) stall_beat(0, 0, "R9");
      stall_beat(1, 0, "R9");
      for (int b = 1; b < n; b++) stall_beat(0, 0, "R9");
      stall_beat(0, 1, "R9");
      clear(2'b10);
    end

    // R8: timer disabled
    cfg_trdy_limit = 0;
    begin_txn();
    for (int b = 1; b <= 300; b++) stall_beat(0, 0, "R8");
    check("R8", sts_trdy_timeout, 0);
    end_txn();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule